// File: doc/BRIEF.md
# Double-Data-Rate ADC Lane Deinterleaver

This block sits directly behind the input buffers of a converter that sends its samples as parallel double-data-rate data. A group of lanes arrives with a data clock that runs at the sample rate. On each lane, one bit of the sample is valid at the rising edge and another bit is valid at the falling edge. The bits are split between the edges by parity. Lane i carries bit 2i at the rising edge and bit 2i+1 at the falling edge. The block captures both edges, weaves the two halves back into one sample and registers it in the data-clock domain. It marks the result with a strobe that stays high once the first full edge pair has been seen.

A parameter selects how the output is coded. It can be left as two's complement with the top bit as sign, or turned into offset binary by inverting the top bit. A ramp monitor, gated by an enable input, flags every sample that does not follow its predecessor by exactly one. This lets a ramp test pattern from the converter prove the wiring and lane mapping before real signals are applied.

Top module: `adc_ddr_deinterleave`

## Requirements
- R1: The value on lane i at the rising data-clock edge becomes output bit 2i of the sample.
- R2: The value on lane i at the falling data-clock edge becomes output bit 2i+1 of the sample.
- R3: A rising-edge capture and the falling-edge capture that follows it form one sample. That sample appears on the output after the next rising edge, and a new sample is produced every data-clock cycle.
- R4: The valid strobe is low after reset. It stays low through the first rising edge after reset and rises only after the first full rising/falling pair. From then on it stays high every cycle.
- R5: With the format parameter set to two's complement, the output bits equal the woven bits unchanged. With offset binary selected, only the top bit (bit 15 at default size) is inverted.
- R6: While the ramp check is enabled, a valid sample that is not the previous valid sample plus one (modulo 2^16) drives the error flag high for exactly the next cycle. The step from 0xFFFF to 0x0000 is not an error.
- R7: Each flagged mismatch adds one to the mismatch count. The count holds at its all-ones maximum instead of wrapping.
- R8: The first valid sample after reset or after the enable rises is not compared. While the enable is low, no error is flagged and the count does not move.
- R9: A synchronous active-high reset clears the held half-words, the output sample, the valid strobe, the error flag and the mismatch count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dclk | input | 1 | Data clock from the converter, one period per sample |
| rst | input | 1 | Synchronous active-high reset |
| lane_d | input | LANES | Data lanes; even sample bits at the rising edge, odd bits at the falling edge |
| chk_en | input | 1 | Enables the ramp monitor |
| sample | output | 2*LANES | Rebuilt sample, coding chosen by FORMAT |
| sample_vld | output | 1 | High while sample holds a complete pair |
| ramp_err | output | 1 | One-cycle pulse per ramp mismatch |
| ramp_miss | output | MISS_W | Saturating count of ramp mismatches |

## Verification
The assertions assume that reset is applied synchronously and that the lanes settle between edges. They also assume that the enable and reset inputs change only away from the rising edge. The bench meets these conditions by changing the even-bit lanes, the enable and the reset one nanosecond after a falling edge, and the odd-bit lanes one nanosecond after a rising edge. Every sample is driven as a complete rising/falling pair with no idle gaps. This keeps the valid strobe continuously high, as the monitor property expects. A second instance, set to offset binary with a narrow counter, gets the same lanes so that the saturation bound can be reached within a short run.

// File: rtl/adc_ddr_pkg.sv
package adc_ddr_pkg;

  // Output coding of the rebuilt sample
  typedef enum logic {
    FMT_TWOS   = 1'b0,
    FMT_OFFSET = 1'b1
  } sample_fmt_e;

endpackage

// File: rtl/ddr_edge_capture.sv
module ddr_edge_capture #(
  parameter int WIDTH   = 8,
  parameter bit FALLING = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  input  logic             tag_in,
  output logic [WIDTH-1:0] q,
  output logic             tag_q
);

  // One register bank, clocked on the edge selected by FALLING
  generate
    if (FALLING) begin : g_fall
      always_ff @(negedge clk) begin
        if (rst) begin
          q     <= '0;
          tag_q <= 1'b0;
        end else begin
          q     <= d;
          tag_q <= tag_in;
        end
      end
    end else begin : g_rise
      always_ff @(posedge clk) begin
        if (rst) begin
          q     <= '0;
          tag_q <= 1'b0;
        end else begin
          q     <= d;
          tag_q <= tag_in;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/sample_merge.sv
module sample_merge
  import adc_ddr_pkg::*;
#(
  parameter int          LANES  = 8,
  parameter sample_fmt_e FORMAT = FMT_TWOS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LANES-1:0]   even_bits,
  input  logic [LANES-1:0]   odd_bits,
  input  logic               pair_ok,
  output logic [2*LANES-1:0] sample_q,
  output logic               valid_q
);

  localparam int SW = 2 * LANES;

  logic [SW-1:0] woven;
  logic [SW-1:0] shaped;

  // Interleave: lane i gives bit 2i (rising half) and bit 2i+1 (falling half)
  for (genvar i = 0; i < LANES; i++) begin : g_weave
    assign woven[2*i]   = even_bits[i];
    assign woven[2*i+1] = odd_bits[i];
  end

  generate
    if (FORMAT == FMT_OFFSET) begin : g_offset
      assign shaped = {~woven[SW-1], woven[SW-2:0]};
    end else begin : g_twos
      assign shaped = woven;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      sample_q <= shaped;
      valid_q  <= pair_ok;
    end
  end

  AST_VALID_STAYS_HIGH: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> valid_q); // R4
  AST_VALID_NEEDS_PAIR: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> $past(pair_ok)); // R3

endmodule

// File: rtl/ramp_monitor.sv
module ramp_monitor #(
  parameter int SW    = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             in_valid,
  input  logic [SW-1:0]    in_sample,
  output logic             err_q,
  output logic [CNT_W-1:0] miss_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic          armed_q;
  logic [SW-1:0] last_q;
  logic          step_bad;

  // Compare only once a predecessor exists
  assign step_bad = armed_q && (in_sample != last_q + SW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      last_q  <= '0;
      err_q   <= 1'b0;
      miss_q  <= '0;
    end else if (!enable) begin
      armed_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (in_valid) begin
      armed_q <= 1'b1;
      last_q  <= in_sample;
      err_q   <= step_bad;
      if (step_bad && (miss_q != CNT_MAX)) begin
        miss_q <= miss_q + CNT_W'(1);
      end
    end else begin
      err_q <= 1'b0;
    end
  end

  AST_ERR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    err_q |-> $past(enable)); // R8
  AST_ERR_NEEDS_PRED: assert property (@(posedge clk) disable iff (rst)
    err_q |-> $past(armed_q)); // R8
  AST_ERR_FROM_VALID: assert property (@(posedge clk) disable iff (rst)
    err_q |-> $past(in_valid)); // R6
  AST_MISS_TRACKS_ERR: assert property (@(posedge clk) disable iff (rst)
    err_q |-> (miss_q == $past(miss_q) + CNT_W'(1)) || (miss_q == CNT_MAX)); // R7
  AST_MISS_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (miss_q == CNT_MAX) |=> (miss_q == CNT_MAX)); // R7

endmodule

// File: rtl/adc_ddr_deinterleave.sv
module adc_ddr_deinterleave
  import adc_ddr_pkg::*;
#(
  parameter int          LANES  = 8,
  parameter sample_fmt_e FORMAT = FMT_TWOS,
  parameter int          MISS_W = 16
) (
  input  logic               dclk,
  input  logic               rst,
  input  logic [LANES-1:0]   lane_d,
  input  logic               chk_en,
  output logic [2*LANES-1:0] sample,
  output logic               sample_vld,
  output logic               ramp_err,
  output logic [MISS_W-1:0]  ramp_miss
);

  localparam int SW = 2 * LANES;

  logic [LANES-1:0] rise_bits;
  logic [LANES-1:0] fall_bits;
  logic             rise_seen;
  logic             pair_ok;

  // Even bits, captured on the rising edge
  ddr_edge_capture #(
    .WIDTH   (LANES),
    .FALLING (1'b0)
  ) u_rise (
    .clk    (dclk),
    .rst    (rst),
    .d      (lane_d),
    .tag_in (1'b1),
    .q      (rise_bits),
    .tag_q  (rise_seen)
  );

  // Odd bits, captured on the falling edge; tag marks a complete pair
  ddr_edge_capture #(
    .WIDTH   (LANES),
    .FALLING (1'b1)
  ) u_fall (
    .clk    (dclk),
    .rst    (rst),
    .d      (lane_d),
    .tag_in (rise_seen),
    .q      (fall_bits),
    .tag_q  (pair_ok)
  );

  sample_merge #(
    .LANES  (LANES),
    .FORMAT (FORMAT)
  ) u_merge (
    .clk       (dclk),
    .rst       (rst),
    .even_bits (rise_bits),
    .odd_bits  (fall_bits),
    .pair_ok   (pair_ok),
    .sample_q  (sample),
    .valid_q   (sample_vld)
  );

  ramp_monitor #(
    .SW    (SW),
    .CNT_W (MISS_W)
  ) u_ramp (
    .clk       (dclk),
    .rst       (rst),
    .enable    (chk_en),
    .in_valid  (sample_vld),
    .in_sample (sample),
    .err_q     (ramp_err),
    .miss_q    (ramp_miss)
  );

  AST_NO_VALID_OUT_OF_RESET: assert property (@(posedge dclk) disable iff (rst)
    $rose(sample_vld) |-> !$past(rst)); // R4
  AST_RESET_CLEARS: assert property (@(posedge dclk)
    $past(rst) |-> (!sample_vld && !ramp_err && (ramp_miss == '0))); // R9

endmodule

// File: tb/adc_ddr_deinterleave_tb.sv
module adc_ddr_deinterleave_tb;
  import adc_ddr_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  lane_d = '0;
  logic        chk_en = 1'b0;
  logic [15:0] sample, sample_ob;
  logic        vld, vld_ob, err, err_ob;
  logic [15:0] miss;
  logic [2:0]  miss_ob;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] expq[$];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk; // 250 MHz

  adc_ddr_deinterleave u_dut (
    .dclk(clk), .rst(rst), .lane_d(lane_d), .chk_en(chk_en),
    .sample(sample), .sample_vld(vld), .ramp_err(err), .ramp_miss(miss));

  adc_ddr_deinterleave #(.FORMAT(FMT_OFFSET), .MISS_W(3)) u_dut_ob (
    .dclk(clk), .rst(rst), .lane_d(lane_d), .chk_en(chk_en),
    .sample(sample_ob), .sample_vld(vld_ob), .ramp_err(err_ob), .ramp_miss(miss_ob));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pick(input logic [15:0] s, input int ofs);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = s[2*i+ofs];
    return r;
  endfunction

  // Driver: entered and left one ns after a falling edge
  task automatic put_sample(input logic [15:0] s, input bit en);
    chk_en = en;
    lane_d = pick(s, 0);
    @(posedge clk); #1;
    lane_d = pick(s, 1);
    expq.push_back(s);
    @(negedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    lane_d = '0;
    repeat (3) @(negedge clk);
    #1;
    expq.delete();
    rst = 1'b0;
  endtask

  function automatic logic [15:0] next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr;
  endfunction

  // Monitor and reference model of the ramp check
  bit          armed = 1'b0;
  logic [15:0] prev = '0;
  int          cnt_a = 0, cnt_b = 0;
  bit          pv = 1'b0;
  logic [15:0] ps = '0;
  int          since = 0;

  always begin
    bit en_e, rst_e, err_x;
    logic [15:0] e;
    @(posedge clk);
    en_e  = chk_en;
    rst_e = rst;
    #1;
    if (!done) begin
      err_x = 1'b0;
      if (rst_e) begin
        armed = 1'b0; cnt_a = 0; cnt_b = 0; since = 0;
        chk(!vld && !vld_ob, "R9 valid", {31'b0, vld}, 0);
        chk(miss == 0 && miss_ob == 0 && !err, "R9 count", {16'b0, miss}, 0);
      end else begin
        since++;
        if (!en_e) begin
          armed = 1'b0;
        end else if (pv) begin
          err_x = armed && (ps != prev + 16'd1);
          if (err_x) begin
            if (cnt_a < 65535) cnt_a++;
            if (cnt_b < 7) cnt_b++;
          end
          prev  = ps;
          armed = 1'b1;
        end
        chk(err == err_x && err_ob == err_x, "R6/R8 ramp_err", {31'b0, err}, {31'b0, err_x});
        chk(miss == cnt_a[15:0], "R7 count", {16'b0, miss}, cnt_a);
        chk(miss_ob == cnt_b[2:0], "R7 saturating count", {29'b0, miss_ob}, cnt_b);
        if (since == 1) chk(!vld, "R4 valid after first edge", {31'b0, vld}, 0);
      end
      if (vld) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R4 unexpected valid", {16'b0, sample}, 0);
        end else begin
          e = expq.pop_front();
          chk(sample == e, "R1/R2/R3 sample", {16'b0, sample}, {16'b0, e});
          chk(sample_ob == (e ^ 16'h8000) && vld_ob, "R5 offset binary", {16'b0, sample_ob}, {16'b0, e ^ 16'h8000});
        end
      end
      pv = vld;
      ps = sample;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    rst = 1'b0;
    // R3/R6: ramp across the sign boundary
    for (int k = 0; k < 33; k++) put_sample(16'h7FF0 + 16'(k), 1'b1);
    // R6: ramp across the 0xFFFF -> 0x0000 wrap
    for (int k = 0; k < 17; k++) put_sample(16'hFFF8 + 16'(k), 1'b1);
    // R7: scattered values, enough mismatches to saturate the narrow counter
    for (int k = 0; k < 14; k++) put_sample(next_rand(), 1'b1);
    // R8: disabled, values unrelated
    for (int k = 0; k < 10; k++) put_sample(next_rand(), 1'b0);
    // R8: re-enable, first sample not compared
    for (int k = 0; k < 8; k++) put_sample(16'h1234 + 16'(k), 1'b1);
    // R1/R2: walking single bit, checker off
    for (int k = 0; k < 16; k++) put_sample(16'h0001 << k, 1'b0);
    for (int k = 0; k < 16; k++) put_sample(~(16'h0001 << k), 1'b0);
    // R9/R4: reset mid-run, then a ramp whose first sample has no predecessor
    do_reset();
    for (int k = 0; k < 12; k++) put_sample(16'hABCD + 16'(k), 1'b1);
    // single glitch in a ramp: two mismatches
    put_sample(16'h0100, 1'b1);
    put_sample(16'h0101, 1'b1);
    put_sample(16'h0300, 1'b1);
    put_sample(16'h0103, 1'b1);
    put_sample(16'h0104, 1'b1);
    put_sample(16'h0105, 1'b1);
    @(posedge clk); #2;
    chk(expq.size() == 0, "R3 all samples emerged", expq.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule